// File: doc/BRIEF.md
# Cascadable BCD Counter Stage

One decimal digit of a synchronous counter. The stored value runs through 0 to 9 and then returns to 0. All state changes happen on the rising clock edge. Three controls act on that edge, each with a set priority. An active-low clear forces the digit to zero. An active-low load copies a 4-bit value into the digit. A pair of enables must both be high for the digit to advance. If none of these acts, the digit keeps its value.

A carry output is high while the digit shows 9 and the chain-side enable is high. It is combinational, so it follows that enable without waiting for a clock edge. To build a multi-digit counter, tie every stage's local enable to one common count strobe and feed each stage's chain-side enable from the carry of the stage below. Each higher digit then steps in the same cycle in which all lower digits wrap.

The stage has no reset of its own. Its value is undefined until the first clock edge with clear held low.

Top module: `decade_stage`

## Requirements
- R1: The digit changes only at a rising edge of `clk`; changes on `clearN`, `loadN`, `enLocal`, `enChain` or `loadVal` between edges leave `count` unchanged.
- R2: With `clearN` low at a rising edge, `count` becomes 0 and `carryOut` is low after that edge, whatever `loadN`, `enLocal`, `enChain` and `loadVal` are.
- R3: With `clearN` high and `loadN` low at a rising edge, `count` takes `loadVal`, and `enLocal`/`enChain` have no effect.
- R4: With `clearN` and `loadN` high and either enable low at a rising edge, `count` keeps its value.
- R5: With `clearN`, `loadN`, `enLocal` and `enChain` all high at a rising edge, `count` advances by one from 0 to 8, and goes from 9 to 0.
- R6: `carryOut` is high exactly when `count` equals 9 (4'b1001) and `enChain` is high, and it follows `enChain` within the same cycle.
- R7: A loaded value from 10 to 15 is held while counting is disabled, and the next enabled count edge sets `count` to 0.
- R8: Three stages chained carry-to-`enChain`, with a common `enLocal`, count 000 to 999 on successive strobes and then wrap to 000; the top stage's carry is high only at 999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clearN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous load, active low |
| enLocal | input | 1 | Count enable shared by all stages |
| enChain | input | 1 | Count enable from the carry of the stage below; also gates `carryOut` |
| loadVal | input | 4 | Value copied in on a load |
| count | output | 4 | Current digit, BCD |
| carryOut | output | 1 | High when the digit is 9 and `enChain` is high |

## Verification
The cases hardest to reach from the ports are the out-of-range values 10 to 15, which normal counting never produces. The only way to reach them is a load. The stimulus loads each such value, holds it with counting disabled to show it persists, and then applies one count edge to show it returns to 0. The priority ordering is covered by loading two different known digits and applying all sixteen combinations of the four controls to each one. The full-carry boundary is covered by a three-stage chain driven through a complete 000-to-999 lap.

// File: rtl/decade_stage_pkg.sv
package decade_stage_pkg;
  localparam int DIGIT_W = 4;
  localparam int LAST_DIGIT = 9;
  localparam logic [DIGIT_W-1:0] LAST_VAL = DIGIT_W'(LAST_DIGIT);
  localparam logic [DIGIT_W-1:0] ZERO_VAL = '0;

  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doStep;
  } stageCtrl_t;
endpackage

// File: rtl/decade_stage_ctrl.sv
module decade_stage_ctrl
  import decade_stage_pkg::*;
(
  input  logic       clearN,
  input  logic       loadN,
  input  logic       enLocal,
  input  logic       enChain,
  output stageCtrl_t ctrl
);
  // Priority: clear, then load, then count; otherwise hold.
  always_comb begin
    ctrl.doClear = !clearN;
    ctrl.doLoad  = clearN && !loadN;
    ctrl.doStep  = clearN && loadN && enLocal && enChain;
  end
endmodule

// File: rtl/decade_stage_path.sv
module decade_stage_path
  import decade_stage_pkg::*;
(
  input  logic               clk,
  input  stageCtrl_t         ctrl,
  input  logic               enChain,
  input  logic [DIGIT_W-1:0] loadVal,
  output logic [DIGIT_W-1:0] count,
  output logic               carryOut
);
  logic [DIGIT_W-1:0] digitQ;
  logic [DIGIT_W-1:0] stepVal;
  logic               atOrPastLast;

  // Any value at or above the last digit folds back to zero on a step.
  assign atOrPastLast = (digitQ >= LAST_VAL);
  assign stepVal      = atOrPastLast ? ZERO_VAL : digitQ + 1'b1;

  always_ff @(posedge clk) begin
    if (ctrl.doClear)     digitQ <= ZERO_VAL;
    else if (ctrl.doLoad) digitQ <= loadVal;
    else if (ctrl.doStep) digitQ <= stepVal;
  end

  assign count    = digitQ;
  assign carryOut = enChain && (digitQ == LAST_VAL);
endmodule

// File: rtl/decade_stage.sv
module decade_stage
  import decade_stage_pkg::*;
(
  input  logic               clk,
  input  logic               clearN,
  input  logic               loadN,
  input  logic               enLocal,
  input  logic               enChain,
  input  logic [DIGIT_W-1:0] loadVal,
  output logic [DIGIT_W-1:0] count,
  output logic               carryOut
);
  stageCtrl_t ctrl;

  decade_stage_ctrl ctrl_i (
    .clearN (clearN),
    .loadN  (loadN),
    .enLocal(enLocal),
    .enChain(enChain),
    .ctrl   (ctrl)
  );

  decade_stage_path path_i (
    .clk     (clk),
    .ctrl    (ctrl),
    .enChain (enChain),
    .loadVal (loadVal),
    .count   (count),
    .carryOut(carryOut)
  );
endmodule

// File: rtl/decade_stage_chk.sv
module decade_stage_chk
  import decade_stage_pkg::*;
(
  input logic               clk,
  input logic               clearN,
  input logic               loadN,
  input logic               enLocal,
  input logic               enChain,
  input logic [DIGIT_W-1:0] loadVal,
  input logic [DIGIT_W-1:0] count,
  input logic               carryOut
);
  // The state is undefined until the first clear, so checks start only after one.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clearN) armed <= 1'b1;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed)
    !clearN |=> (count == ZERO_VAL && !carryOut)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!armed)
    (clearN && !loadN) |=> count == $past(loadVal)); // R3
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && !(enLocal && enChain)) |=> $stable(count)); // R4
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && enLocal && enChain && count < LAST_VAL) |=> count == $past(count) + 1'b1); // R5
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && enLocal && enChain && count >= LAST_VAL) |=> count == ZERO_VAL); // R7
  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!armed)
    carryOut |-> (enChain && count == LAST_VAL)); // R6
endmodule

bind decade_stage decade_stage_chk chk_i (.*);

// File: tb/decade_stage_tb_top.sv
module decade_stage_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;

  logic       clearN = 1'b1, loadN = 1'b1, enLocal = 1'b0, enChain = 1'b0;
  logic [3:0] loadVal = 4'd0;
  logic [3:0] count;
  logic       carryOut;

  decade_stage dut_i (
    .clk(clk), .clearN(clearN), .loadN(loadN), .enLocal(enLocal),
    .enChain(enChain), .loadVal(loadVal), .count(count), .carryOut(carryOut)
  );

  // Three-stage chain for R8
  logic       chClearN = 1'b1, chEn = 1'b0;
  logic [3:0] chDigit [3];
  logic       chCarry [3];
  for (genvar g = 0; g < 3; g++) begin : g_chain
    logic trickleIn;
    if (g == 0) begin : g_first
      assign trickleIn = chEn;
    end else begin : g_next
      assign trickleIn = chCarry[g-1];
    end
    decade_stage st_i (
      .clk(clk), .clearN(chClearN), .loadN(1'b1), .enLocal(chEn),
      .enChain(trickleIn), .loadVal(4'd0), .count(chDigit[g]), .carryOut(chCarry[g])
    );
  end

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge, pass the rising edge, sample 1 ns later.
  task automatic cycle(input logic c, input logic l, input logic ep, input logic et, input logic [3:0] d);
    @(negedge clk);
    clearN = c; loadN = l; enLocal = ep; enChain = et; loadVal = d;
    @(posedge clk);
    #1;
  endtask

  task automatic t_clear();
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 4'd7);
    chk("R2 clear beats load", count, 0);
    chk("R2 carry low after clear", carryOut, 0);
  endtask

  task automatic t_priority();
    foreach (loadVal[i]) begin end
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 16; m++) begin
        logic [3:0] start;
        logic c, l, ep, et;
        int exp;
        start = (s == 0) ? 4'd4 : 4'd9;
        c = m[3]; l = m[2]; ep = m[1]; et = m[0];
        cycle(1'b1, 1'b0, 1'b0, 1'b0, start);
        cycle(c, l, ep, et, 4'd2);
        if (!c) exp = 0;
        else if (!l) exp = 2;
        else if (ep && et) exp = (start == 4'd9) ? 0 : start + 1;
        else exp = start;
        if (!c) chk("R2 priority clear", count, exp);
        else if (!l) chk("R3 priority load", count, exp);
        else if (ep && et) chk("R5 priority count", count, exp);
        else chk("R4 priority hold", count, exp);
      end
    end
  endtask

  task automatic t_sequence();
    cycle(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    for (int k = 1; k <= 12; k++) begin
      cycle(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
      chk("R5 count sequence", count, k % 10);
    end
  endtask

  task automatic t_between_edges();
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 4'd3);
    @(negedge clk);
    clearN = 1'b0; loadN = 1'b0; loadVal = 4'd8; enLocal = 1'b1; enChain = 1'b1;
    #2;
    chk("R1 no change between edges", count, 3);
    clearN = 1'b1; loadN = 1'b1; enLocal = 1'b0;
    #1;
    chk("R1 still unchanged before edge", count, 3);
  endtask

  task automatic t_carry();
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 4'd9);
    chk("R6 carry at 9 with chain enable", carryOut, 1);
    @(negedge clk);
    loadN = 1'b1; enLocal = 1'b0; enChain = 1'b0;
    #1;
    chk("R6 carry follows chain enable low", carryOut, 0);
    enChain = 1'b1;
    #1;
    chk("R6 carry follows chain enable high", carryOut, 1);
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 4'd8);
    chk("R6 no carry at 8", carryOut, 0);
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 4'd11);
    chk("R6 no carry at 11 (1011)", carryOut, 0);
  endtask

  task automatic t_invalid();
    for (int v = 10; v < 16; v++) begin
      cycle(1'b1, 1'b0, 1'b0, 1'b0, 4'(v));
      cycle(1'b1, 1'b1, 1'b1, 1'b0, 4'd0);
      chk("R7 out-of-range value held", count, v);
      cycle(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
      chk("R7 out-of-range steps to 0", count, 0);
    end
  endtask

  task automatic t_chain();
    int val;
    @(negedge clk); chClearN = 1'b0; chEn = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); chClearN = 1'b1; chEn = 1'b1;
    for (int n = 1; n <= 1000; n++) begin
      @(posedge clk); #1;
      val = chDigit[2] * 100 + chDigit[1] * 10 + chDigit[0];
      chk("R8 chain value", val, n % 1000);
      chk("R8 top carry only at 999", chCarry[2], (n % 1000 == 999) ? 1 : 0);
    end
    @(negedge clk); chEn = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_clear();
    t_priority();
    t_sequence();
    t_between_edges();
    t_carry();
    t_invalid();
    t_chain();
    report();
  end
endmodule